// File: doc/BRIEF.md
# Video and Memory Clock Select Controller

This block is the digital selection and control logic of a dual clock generator that feeds a graphics controller. The synthesizers are outside the block: it sees them as a bank of fifteen free-running video-rate clock inputs, eight memory-rate clock inputs and one external clock. From these it forwards one source to the video clock output and one to the memory clock output. Each output has its own drive-enable, and a power-down input overrides both. The video choice comes from a 4-bit code. The host writes the two low bits of that code through a strobe that is active low. The two high bits are wired straight through from pins.

Pin inputs, including the strobe, are asynchronous to the block clock `clk`. The strobe, the two captured select bits and the power-down input pass through two-flop synchronizers. A small capture state machine then sees them. It has three states. CAP_IDLE waits for the strobe to fall. CAP_ARMED follows the select bits while the strobe is low, and on its rise commits them to the low half of the video code and returns to CAP_IDLE. CAP_HOLD is entered when power-down is seen in CAP_IDLE with the strobe low, or at any time in CAP_ARMED. It discards the pulse and returns to CAP_IDLE only once the strobe is high and power is up. Because of this, a host that keeps the strobe low across a power cycle keeps its last video choice. Each output is then chosen by a plain combinational multiplexer, followed by a stage that applies power-down and the enable.

The current video and memory codes are brought out as status. This lets a selection be checked without measuring any frequency. Among the video sources, index 0 is the 30.0 MHz source, index 11 the 25.175 MHz source and index 12 the 28.322 MHz source. Among the memory sources, index 0 is 33.0 MHz and index 7 is 44.296 MHz.

Top module: `dual_clk_sel`

## Requirements
- R1: After synchronous reset (`rst_n` low at a `clk` edge), the captured low half of the video code is 00 and the capture state machine is in CAP_IDLE.
- R2: `vcode[1:0]` takes the value held on `vsel_lo` at the end of a low pulse on `strobe_n`, within four `clk` cycles of the rising edge. It does not change while the strobe stays low, and it does not change while the strobe stays high.
- R3: `vcode[3:2]` always equals `vsel_hi`, with no capture and no clock delay.
- R4: When `vcode` is 4'b0010, `vclk` follows `ext_clk`.
- R5: For any other `vcode` value c, `vclk` follows `vsrc[c]` when c is below 2, and `vsrc[c-1]` when c is above 2.
- R6: `mclk` follows `msrc[msel]`, and `mcode` equals `msel`.
- R7: With `pwr_n` high, `vclk_oe` equals `ven` and `mclk_oe` equals `men`. A low oe means the pad is high impedance.
- R8: With `pwr_n` low, `vclk` and `mclk` are both 1 and both oe outputs are 1, whatever the enables and sources are.
- R9: A strobe pulse that starts while power-down is active leaves `vcode[1:0]` unchanged, even if it ends after power returns.
- R10: If the strobe is held low from before power-down until after power-up and then released, `vcode[1:0]` keeps the value it had before power-down, even if `vsel_lo` changed meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for synchronizers and capture logic |
| rst_n | input | 1 | Synchronous reset, active low |
| vsrc | input | 15 | Internally generated video-rate clocks |
| msrc | input | 8 | Internally generated memory-rate clocks |
| ext_clk | input | 1 | External clock, routable to the video output |
| vsel_lo | input | 2 | Video select bits captured by the strobe |
| vsel_hi | input | 2 | Video select bits used live |
| strobe_n | input | 1 | Capture strobe, active low |
| msel | input | 3 | Memory clock select code |
| ven | input | 1 | Video output drive enable, active high |
| men | input | 1 | Memory output drive enable, active high |
| pwr_n | input | 1 | Power-down, active low |
| vclk | output | 1 | Video clock output value |
| vclk_oe | output | 1 | Video output drive enable (0 = high impedance) |
| mclk | output | 1 | Memory clock output value |
| mclk_oe | output | 1 | Memory output drive enable (0 = high impedance) |
| vcode | output | 4 | Current video select code |
| mcode | output | 3 | Current memory select code |

## Verification
The bench sweeps all sixteen video codes, placing a lone 1 and then a lone 0 on the expected source. A multiplexer that drops the wrong index around the external-clock slot would forward a neighbouring source and miss both. It samples the code in the middle of a strobe pulse and after data changes with the strobe high, which catches a transparent latch or a capture on the falling edge. It drives both power-down orderings: a pulse that starts during power-down, and a strobe held low across a power cycle. A design that commits on any rising strobe edge would load the changed select bits in both cases. With both enables low, it checks that power-down still drives both outputs high rather than leaving them high impedance.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
    localparam int VCODE_W  = 4;
    localparam int LO_W     = 2;
    localparam int HI_W     = VCODE_W - LO_W;
    localparam int MCODE_W  = 3;
    localparam int N_VCODES = 1 << VCODE_W;
    localparam int N_VSRC   = N_VCODES - 1;
    localparam int N_MSRC   = 1 << MCODE_W;
    localparam int EXT_CODE = 2;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_HOLD  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/vsel_capture.sv
module vsel_capture
    import clk_sel_pkg::*;
#(
    parameter int W = LO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_n_s,
    input  logic         awake_s,
    input  logic [W-1:0] data_s,
    output logic [W-1:0] code_lo,
    output cap_state_t   state
);
    cap_state_t   state_nx;
    logic         commit;
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        commit   = 1'b0;
        unique case (state)
            CAP_IDLE: begin
                if (!strobe_n_s) state_nx = awake_s ? CAP_ARMED : CAP_HOLD;
            end
            CAP_ARMED: begin
                if (!awake_s) begin
                    state_nx = CAP_HOLD;
                end else if (strobe_n_s) begin
                    state_nx = CAP_IDLE;
                    commit   = 1'b1;
                end
            end
            CAP_HOLD: begin
                if (strobe_n_s && awake_s) state_nx = CAP_IDLE;
            end
            default: state_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            code_lo <= '0;
        end else begin
            if (!strobe_n_s && awake_s) pend <= data_s;
            if (commit)                 code_lo <= pend;
        end
    end
endmodule

// File: rtl/clk_mux.sv
module clk_mux #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     src,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    always_comb begin
        y = 1'b0;
        if (int'(sel) < N) y = src[sel];
    end
endmodule

// File: rtl/out_stage.sv
module out_stage (
    input  logic awake,
    input  logic en,
    input  logic clk_in,
    output logic drv,
    output logic oe
);
    always_comb begin
        if (!awake) begin
            drv = 1'b1;
            oe  = 1'b1;
        end else begin
            drv = clk_in;
            oe  = en;
        end
    end
endmodule

// File: rtl/dual_clk_sel.sv
module dual_clk_sel
    import clk_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_VSRC-1:0]  vsrc,
    input  logic [N_MSRC-1:0]  msrc,
    input  logic               ext_clk,
    input  logic [LO_W-1:0]    vsel_lo,
    input  logic [HI_W-1:0]    vsel_hi,
    input  logic               strobe_n,
    input  logic [MCODE_W-1:0] msel,
    input  logic               ven,
    input  logic               men,
    input  logic               pwr_n,
    output logic               vclk,
    output logic               vclk_oe,
    output logic               mclk,
    output logic               mclk_oe,
    output logic [VCODE_W-1:0] vcode,
    output logic [MCODE_W-1:0] mcode
);
    logic               strobe_n_s;
    logic               awake_s;
    logic [LO_W-1:0]    lo_s;
    logic [LO_W-1:0]    code_lo;
    cap_state_t         cap_state;
    logic [N_VCODES-1:0] vbank;
    logic               vmux;
    logic               mmux;

    pin_sync #(.W(1), .RST_VAL(1'b1)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(strobe_n_s));
    pin_sync #(.W(1), .RST_VAL(1'b1)) u_sync_pwr (
        .clk(clk), .rst_n(rst_n), .d(pwr_n), .q(awake_s));
    pin_sync #(.W(LO_W), .RST_VAL('0)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .d(vsel_lo), .q(lo_s));

    vsel_capture #(.W(LO_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .strobe_n_s(strobe_n_s), .awake_s(awake_s),
        .data_s(lo_s), .code_lo(code_lo), .state(cap_state));

    assign vcode = {vsel_hi, code_lo};
    assign mcode = msel;

    for (genvar c = 0; c < N_VCODES; c++) begin : g_vbank
        if (c == EXT_CODE) begin : g_ext
            assign vbank[c] = ext_clk;
        end else begin : g_int
            localparam int SI = (c < EXT_CODE) ? c : c - 1;
            assign vbank[c] = vsrc[SI];
        end
    end

    clk_mux #(.N(N_VCODES), .SEL_W(VCODE_W)) u_vmux (
        .src(vbank), .sel(vcode), .y(vmux));
    clk_mux #(.N(N_MSRC), .SEL_W(MCODE_W)) u_mmux (
        .src(msrc), .sel(msel), .y(mmux));

    out_stage u_vout (.awake(pwr_n), .en(ven), .clk_in(vmux), .drv(vclk), .oe(vclk_oe));
    out_stage u_mout (.awake(pwr_n), .en(men), .clk_in(mmux), .drv(mclk), .oe(mclk_oe));
endmodule

// File: rtl/dual_clk_sel_chk.sv
module dual_clk_sel_chk
    import clk_sel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_n,
    input logic               strobe_n,
    input logic [HI_W-1:0]    vsel_hi,
    input logic [MCODE_W-1:0] msel,
    input logic               vclk,
    input logic               mclk,
    input logic               vclk_oe,
    input logic               mclk_oe,
    input logic [VCODE_W-1:0] vcode,
    input logic [MCODE_W-1:0] mcode
);
    // R8
    pwrdn_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |-> (vclk && mclk && vclk_oe && mclk_oe));

    // R3
    hi_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcode[VCODE_W-1:LO_W] == vsel_hi);

    // R2
    commit_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode[LO_W-1:0] != $past(vcode[LO_W-1:0])) |-> $past(strobe_n));

    // R9
    no_capture_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pwr_n, 3) |-> $stable(vcode[LO_W-1:0]));

    // R6
    mcode_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcode == msel);
endmodule

bind dual_clk_sel dual_clk_sel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .strobe_n(strobe_n),
    .vsel_hi(vsel_hi), .msel(msel), .vclk(vclk), .mclk(mclk),
    .vclk_oe(vclk_oe), .mclk_oe(mclk_oe), .vcode(vcode), .mcode(mcode));

// File: tb/dual_clk_sel_tb.sv
module dual_clk_sel_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] vsrc = '0;
    logic [7:0]  msrc = '0;
    logic        ext_clk = 1'b0;
    logic [1:0]  vsel_lo = '0;
    logic [1:0]  vsel_hi = '0;
    logic        strobe_n = 1'b1;
    logic [2:0]  msel = '0;
    logic        ven = 1'b1;
    logic        men = 1'b1;
    logic        pwr_n = 1'b1;
    logic        vclk, vclk_oe, mclk, mclk_oe;
    logic [3:0]  vcode;
    logic [2:0]  mcode;

    typedef struct {
        string      req;
        int         kind;
        logic [3:0] exp;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    dual_clk_sel u_dut (
        .clk(clk), .rst_n(rst_n), .vsrc(vsrc), .msrc(msrc), .ext_clk(ext_clk),
        .vsel_lo(vsel_lo), .vsel_hi(vsel_hi), .strobe_n(strobe_n), .msel(msel),
        .ven(ven), .men(men), .pwr_n(pwr_n), .vclk(vclk), .vclk_oe(vclk_oe),
        .mclk(mclk), .mclk_oe(mclk_oe), .vcode(vcode), .mcode(mcode));

    // kinds: 0 vclk, 1 vclk_oe, 2 mclk, 3 mclk_oe, 4 vcode, 5 mcode, 6 vcode low bits
    function automatic logic [3:0] actual(int kind);
        case (kind)
            0: return {3'b0, vclk};
            1: return {3'b0, vclk_oe};
            2: return {3'b0, mclk};
            3: return {3'b0, mclk_oe};
            4: return vcode;
            5: return {1'b0, mcode};
            default: return {2'b0, vcode[1:0]};
        endcase
    endfunction

    task automatic expect_val(string req, int kind, logic [3:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(logic [1:0] d);
        vsel_lo = d;
        cyc(3);
        strobe_n = 1'b0;
        cyc(3);
        strobe_n = 1'b1;
        cyc(5);
    endtask

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [3:0] a;
                it = sb.pop_front();
                a = actual(it.kind);
                n_chk++;
                if (a !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind %0d: actual %0h expected %0h", it.req, it.kind, a, it.exp);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        expect_val("R1", 4, 4'b0000);
        cyc(1);

        // R2 capture at end of pulse, not during it
        vsel_lo = 2'b11;
        cyc(3);
        strobe_n = 1'b0;
        cyc(4);
        expect_val("R2 mid-pulse", 6, 4'b0000);
        cyc(1);
        strobe_n = 1'b1;
        cyc(5);
        expect_val("R2 committed", 6, 4'b0011);
        cyc(1);
        // R2 held while strobe high
        vsel_lo = 2'b01;
        cyc(6);
        expect_val("R2 hold", 6, 4'b0011);
        cyc(1);

        // R3 live high bits
        vsel_hi = 2'b10;
        #1;
        expect_val("R3", 4, 4'b1011);
        cyc(1);

        // R4 and R5 full sweep of video codes
        for (int lo = 0; lo < 4; lo++) begin
            pulse(lo[1:0]);
            for (int hi = 0; hi < 4; hi++) begin
                int code;
                code = hi * 4 + lo;
                vsel_hi = hi[1:0];
                if (code == 2) begin
                    vsrc = '0; ext_clk = 1'b1;
                    #1; expect_val("R4 ext high", 0, 4'd1);
                    cyc(1);
                    vsrc = '1; ext_clk = 1'b0;
                    #1; expect_val("R4 ext low", 0, 4'd0);
                    cyc(1);
                end else begin
                    int si;
                    si = (code < 2) ? code : code - 1;
                    ext_clk = 1'b0; vsrc = 15'(1) << si;
                    #1; expect_val("R5 one", 0, 4'd1);
                    cyc(1);
                    ext_clk = 1'b1; vsrc = ~(15'(1) << si);
                    #1; expect_val("R5 zero", 0, 4'd0);
                    cyc(1);
                end
            end
        end

        // R6 memory sweep
        for (int m = 0; m < 8; m++) begin
            msel = m[2:0];
            msrc = 8'(1) << m;
            #1; expect_val("R6 one", 2, 4'd1);
            expect_val("R6 code", 5, 4'(m));
            cyc(1);
            msrc = ~(8'(1) << m);
            #1; expect_val("R6 zero", 2, 4'd0);
            cyc(1);
        end

        // R7 enables
        ven = 1'b0; men = 1'b1;
        #1; expect_val("R7 ven", 1, 4'd0); expect_val("R7 men", 3, 4'd1);
        cyc(1);
        ven = 1'b1; men = 1'b0;
        #1; expect_val("R7 ven", 1, 4'd1); expect_val("R7 men", 3, 4'd0);
        cyc(1);

        // R8 power-down forces high and driven
        ven = 1'b0; men = 1'b0; vsrc = '0; msrc = '0; ext_clk = 1'b0;
        pwr_n = 1'b0;
        #1;
        expect_val("R8 vclk", 0, 4'd1); expect_val("R8 voe", 1, 4'd1);
        expect_val("R8 mclk", 2, 4'd1); expect_val("R8 moe", 3, 4'd1);
        cyc(4);

        // R9 pulse starting in power-down is discarded (current low bits 11)
        pulse(2'b00);
        vsel_lo = 2'b10;
        strobe_n = 1'b0;
        cyc(4);
        pwr_n = 1'b1;
        cyc(4);
        strobe_n = 1'b1;
        cyc(6);
        expect_val("R9", 6, 4'b0011);
        cyc(1);
        ven = 1'b1; men = 1'b1;

        // R10 strobe held low across power cycle
        pulse(2'b01);
        expect_val("R10 pre", 6, 4'b0001);
        cyc(1);
        strobe_n = 1'b0;
        cyc(4);
        pwr_n = 1'b0;
        cyc(4);
        vsel_lo = 2'b10;
        cyc(4);
        pwr_n = 1'b1;
        cyc(4);
        strobe_n = 1'b1;
        cyc(6);
        expect_val("R10", 6, 4'b0001);
        cyc(1);
        // R2 normal capture still works afterwards
        pulse(2'b10);
        expect_val("R2 after", 6, 4'b0010);
        cyc(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule